// File: doc/BRIEF.md
# Interrupt Request Capture and Acknowledge Sequencer

This block is the front end of a legacy-style eight-input programmable interrupt controller. It synchronizes the raw request lines, records each request in a pending register according to the selected trigger mode, raises an interrupt line to the processor, and answers a two-pulse acknowledge handshake with the offset of the winning input. Priority is fixed: a lower input number always wins.

The trigger mode behaves unusually. In edge mode, a rising input only arms a request. The request is still cancelled if the line falls again. It is delivered only if the line stays high until the second acknowledge pulse. A request that vanishes between the two pulses produces a spurious answer, which carries the offset of the last input and sets no in-service bit. Level mode differs from edge mode only in that no leading edge is required. A non-specific end-of-interrupt strobe retires the highest-priority request in service.

The mask and the trigger mode are held in small registers, each loaded through its own write strobe.

Top module: `pic_irq_capture`

## Requirements
- R1: After reset, the pending bits and the in-service bits are all zero, every input is masked (mask all ones), and edge mode is selected.
- R2: In edge mode, a pending bit is set only by a low-to-high change of its synchronized input. After the bit is granted, it stays clear while the input remains high, until a new rising edge arrives.
- R3: In level mode, a high synchronized input sets its pending bit with no edge needed. While the input is still high, the bit is set again on the cycle after a grant.
- R4: In both modes, a low synchronized input clears its pending bit. Each input passes through a two-flop synchronizer with no glitch filter.
- R5: `int_o` is high exactly when some pending bit is unmasked and no in-service bit of equal or lower index is set.
- R6: On the rising edge of the first acknowledge pulse, the lowest-index pending bit that is unmasked and not blocked by service is frozen as the candidate. Requests that arrive later do not replace it.
- R7: On the rising edge of the second acknowledge pulse, if the candidate is still pending, three things happen: its in-service bit is set, its pending bit is cleared, and its index (0 to 7) is output on `vec_o`. At the same time `vec_valid_o` pulses for one cycle with `spurious_o` low.
- R8: If the candidate's input has dropped before the second pulse, the answer is spurious. `vec_o` is 7, `spurious_o` and `vec_valid_o` are high for one cycle, and no in-service bit changes.
- R9: A request whose input drops before the first acknowledge pulse is lost. `int_o` falls, and a following acknowledge sequence with nothing else pending answers spurious.
- R10: A one-cycle `eoi_i` pulse clears only the lowest-index set in-service bit.
- R11: A write on `mask_we_i` loads the mask (bit set means masked). A masked input still shows in `irr_o`, but it neither raises `int_o` nor becomes a candidate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 8 | Raw interrupt request lines |
| mode_we_i | input | 1 | Load strobe for the trigger mode |
| mode_level_i | input | 1 | Trigger mode to load: 1 level, 0 edge |
| mask_we_i | input | 1 | Load strobe for the mask |
| mask_wdata_i | input | 8 | Mask value to load, 1 = masked |
| inta_i | input | 1 | Acknowledge pulse from the processor |
| eoi_i | input | 1 | Non-specific end-of-interrupt strobe |
| irr_o | output | 8 | Pending request bits |
| isr_o | output | 8 | In-service bits |
| int_o | output | 1 | Interrupt request to the processor |
| vec_valid_o | output | 1 | One-cycle pulse after the second acknowledge pulse |
| vec_o | output | 3 | Answered input offset |
| spurious_o | output | 1 | Answer is spurious (valid with vec_valid_o) |

## Verification
A pending bit that is stuck or cleared wrongly shows on `irr_o` and `int_o` three cycles after the input change, because the synchronizer and the pending register lie on that path. A wrong candidate or a lost cancellation shows up in the answer on the cycle after the second acknowledge pulse, as a wrong offset or a wrong spurious flag. The in-service state becomes visible at the same time on `isr_o`. After that it stays visible through `int_o` blocking, which tells whether a later request is let through or not. Errors in end-of-interrupt ordering are seen one cycle after the strobe, because the wrong bit is left set in `isr_o`.

// File: rtl/pic_pkg.sv
package pic_pkg;

    typedef enum logic {
        ACK_IDLE  = 1'b0,
        ACK_WAIT2 = 1'b1
    } ack_state_e;

endpackage

// File: rtl/pic_req_sync.sv
module pic_req_sync #(
    parameter int N_REQ  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [N_REQ-1:0] req_i,
    output logic [N_REQ-1:0] req_sync_o,
    output logic [N_REQ-1:0] req_rise_o
);
    typedef struct packed {
        logic [STAGES-1:0][N_REQ-1:0] pipe;
        logic [N_REQ-1:0]             prev;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d         = s_q;
        s_d.pipe[0] = req_i;
        for (int k = 1; k < STAGES; k++) begin
            s_d.pipe[k] = s_q.pipe[k-1];
        end
        s_d.prev = s_q.pipe[STAGES-1];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign req_sync_o = s_q.pipe[STAGES-1];
    assign req_rise_o = s_q.pipe[STAGES-1] & ~s_q.prev;

endmodule

// File: rtl/pic_req_latch.sv
module pic_req_latch #(
    parameter int N_REQ = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [N_REQ-1:0] req_sync_i,
    input  logic [N_REQ-1:0] req_rise_i,
    input  logic             level_mode_i,
    input  logic [N_REQ-1:0] grant_clr_i,
    output logic [N_REQ-1:0] irr_o
);
    typedef struct packed {
        logic [N_REQ-1:0] irr;
    } latch_t;

    latch_t l_d, l_q;

    always_comb begin
        l_d = l_q;
        for (int i = 0; i < N_REQ; i++) begin
            if (!req_sync_i[i]) begin
                l_d.irr[i] = 1'b0;
            end else if (grant_clr_i[i]) begin
                l_d.irr[i] = 1'b0;
            end else if (level_mode_i || req_rise_i[i]) begin
                l_d.irr[i] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) l_q <= '0;
        else         l_q <= l_d;
    end

    assign irr_o = l_q.irr;

endmodule

// File: rtl/pic_ack_seq.sv
module pic_ack_seq
    import pic_pkg::*;
#(
    parameter int N_REQ = 8,
    localparam int VEC_W = $clog2(N_REQ)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             inta_i,
    input  logic             eoi_i,
    input  logic [N_REQ-1:0] irr_i,
    input  logic [N_REQ-1:0] mask_i,
    output logic [N_REQ-1:0] grant_clr_o,
    output logic [N_REQ-1:0] isr_o,
    output logic             int_o,
    output logic             vec_valid_o,
    output logic [VEC_W-1:0] vec_o,
    output logic             spurious_o
);
    localparam logic [VEC_W-1:0] SPUR_VEC = VEC_W'(N_REQ - 1);

    typedef struct packed {
        ack_state_e       state;
        logic             inta_prev;
        logic             cand_valid;
        logic [VEC_W-1:0] cand;
        logic [N_REQ-1:0] isr;
        logic             vec_valid;
        logic [VEC_W-1:0] vec;
        logic             spurious;
    } seq_t;

    seq_t s_d, s_q;

    logic [N_REQ-1:0] blocked;
    logic [N_REQ-1:0] eligible;
    logic             pick_found;
    logic [VEC_W-1:0] pick_idx;
    logic [N_REQ-1:0] isr_eoi;
    logic             inta_rise;

    // bit i is blocked when any in-service bit at index 0..i is set
    always_comb begin
        logic acc;
        acc = 1'b0;
        for (int i = 0; i < N_REQ; i++) begin
            acc        = acc | s_q.isr[i];
            blocked[i] = acc;
        end
    end

    assign eligible = irr_i & ~mask_i & ~blocked;

    always_comb begin
        pick_found = 1'b0;
        pick_idx   = '0;
        for (int i = N_REQ - 1; i >= 0; i--) begin
            if (eligible[i]) begin
                pick_found = 1'b1;
                pick_idx   = VEC_W'(i);
            end
        end
    end

    always_comb begin
        logic hit;
        isr_eoi = s_q.isr;
        hit     = 1'b0;
        if (eoi_i) begin
            for (int i = 0; i < N_REQ; i++) begin
                if (!hit && s_q.isr[i]) begin
                    isr_eoi[i] = 1'b0;
                    hit        = 1'b1;
                end
            end
        end
    end

    assign inta_rise = inta_i & ~s_q.inta_prev;

    always_comb begin
        s_d           = s_q;
        s_d.inta_prev = inta_i;
        s_d.vec_valid = 1'b0;
        s_d.spurious  = 1'b0;
        s_d.isr       = isr_eoi;
        grant_clr_o   = '0;
        unique case (s_q.state)
            ACK_IDLE: begin
                if (inta_rise) begin
                    s_d.cand_valid = pick_found;
                    s_d.cand       = pick_idx;
                    s_d.state      = ACK_WAIT2;
                end
            end
            ACK_WAIT2: begin
                if (inta_rise) begin
                    s_d.vec_valid = 1'b1;
                    s_d.state     = ACK_IDLE;
                    if (s_q.cand_valid && irr_i[s_q.cand]) begin
                        s_d.isr[s_q.cand]      = 1'b1;
                        grant_clr_o[s_q.cand]  = 1'b1;
                        s_d.vec                = s_q.cand;
                    end else begin
                        s_d.vec      = SPUR_VEC;
                        s_d.spurious = 1'b1;
                    end
                end
            end
            default: s_d.state = ACK_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign isr_o       = s_q.isr;
    assign int_o       = |eligible;
    assign vec_valid_o = s_q.vec_valid;
    assign vec_o       = s_q.vec;
    assign spurious_o  = s_q.spurious;

endmodule

// File: rtl/pic_irq_capture.sv
module pic_irq_capture #(
    parameter int N_REQ       = 8,
    parameter int SYNC_STAGES = 2,
    localparam int VEC_W = $clog2(N_REQ)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [N_REQ-1:0] req_i,
    input  logic             mode_we_i,
    input  logic             mode_level_i,
    input  logic             mask_we_i,
    input  logic [N_REQ-1:0] mask_wdata_i,
    input  logic             inta_i,
    input  logic             eoi_i,
    output logic [N_REQ-1:0] irr_o,
    output logic [N_REQ-1:0] isr_o,
    output logic             int_o,
    output logic             vec_valid_o,
    output logic [VEC_W-1:0] vec_o,
    output logic             spurious_o
);
    typedef struct packed {
        logic [N_REQ-1:0] mask;
        logic             level;
    } cfg_t;

    cfg_t c_d, c_q;

    logic [N_REQ-1:0] req_sync;
    logic [N_REQ-1:0] req_rise;
    logic [N_REQ-1:0] grant_clr;
    logic [N_REQ-1:0] mask_q;
    logic             level_q;

    always_comb begin
        c_d = c_q;
        if (mask_we_i) c_d.mask  = mask_wdata_i;
        if (mode_we_i) c_d.level = mode_level_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            c_q.mask  <= '1;
            c_q.level <= 1'b0;
        end else begin
            c_q <= c_d;
        end
    end

    assign mask_q  = c_q.mask;
    assign level_q = c_q.level;

    pic_req_sync #(.N_REQ(N_REQ), .STAGES(SYNC_STAGES)) u_sync (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .req_i      (req_i),
        .req_sync_o (req_sync),
        .req_rise_o (req_rise)
    );

    pic_req_latch #(.N_REQ(N_REQ)) u_latch (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .req_sync_i   (req_sync),
        .req_rise_i   (req_rise),
        .level_mode_i (level_q),
        .grant_clr_i  (grant_clr),
        .irr_o        (irr_o)
    );

    pic_ack_seq #(.N_REQ(N_REQ)) u_seq (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .inta_i      (inta_i),
        .eoi_i       (eoi_i),
        .irr_i       (irr_o),
        .mask_i      (mask_q),
        .grant_clr_o (grant_clr),
        .isr_o       (isr_o),
        .int_o       (int_o),
        .vec_valid_o (vec_valid_o),
        .vec_o       (vec_o),
        .spurious_o  (spurious_o)
    );

endmodule

// File: rtl/pic_irq_capture_chk.sv
module pic_irq_capture_chk #(
    parameter int N_REQ = 8,
    localparam int VEC_W = $clog2(N_REQ)
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             eoi_i,
    input logic [N_REQ-1:0] irr_o,
    input logic [N_REQ-1:0] isr_o,
    input logic             int_o,
    input logic             vec_valid_o,
    input logic [VEC_W-1:0] vec_o,
    input logic             spurious_o,
    input logic [N_REQ-1:0] req_sync,
    input logic [N_REQ-1:0] mask_q,
    input logic             level_q
);
    for (genvar g = 0; g < N_REQ; g++) begin : g_bit
        AST_FALL_CLEARS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
            !req_sync[g] |=> !irr_o[g]); // R4
        AST_SET_NEEDS_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
            $rose(irr_o[g]) |-> $past(req_sync[g])); // R3
        AST_EDGE_NEEDS_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
            ($rose(irr_o[g]) && !$past(level_q)) |-> !$past(req_sync[g], 2)); // R2
    end

    AST_GRANT_SETS_ISR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (vec_valid_o && !spurious_o) |-> (isr_o[vec_o] && !irr_o[vec_o])); // R7
    AST_ONE_NEW_ISR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(isr_o & ~$past(isr_o))); // R7
    AST_SPURIOUS_VEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (vec_valid_o && spurious_o) |-> (vec_o == VEC_W'(N_REQ - 1))); // R8
    AST_SPURIOUS_KEEPS_ISR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (vec_valid_o && spurious_o && !$past(eoi_i)) |-> (isr_o == $past(isr_o))); // R8
    AST_INT_UNMASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        int_o |-> |(irr_o & ~mask_q)); // R11
    AST_EOI_ONE_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(eoi_i) && !vec_valid_o) |-> ($countones($past(isr_o) & ~isr_o) <= 1)); // R10

endmodule

bind pic_irq_capture pic_irq_capture_chk #(.N_REQ(N_REQ)) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .eoi_i       (eoi_i),
    .irr_o       (irr_o),
    .isr_o       (isr_o),
    .int_o       (int_o),
    .vec_valid_o (vec_valid_o),
    .vec_o       (vec_o),
    .spurious_o  (spurious_o),
    .req_sync    (req_sync),
    .mask_q      (mask_q),
    .level_q     (level_q)
);

// File: tb/pic_irq_capture_tb_top.sv
`timescale 1ns/1ps
module pic_irq_capture_tb_top;
    logic       clk = 1'b0;
    logic       rst_ni = 1'b0;
    logic [7:0] req = '0;
    logic       mode_we = 1'b0, mode_level = 1'b0;
    logic       mask_we = 1'b0;
    logic [7:0] mask_wdata = '0;
    logic       inta = 1'b0, eoi = 1'b0;
    logic [7:0] irr, isr;
    logic       intr, vec_valid, spurious;
    logic [2:0] vec;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    typedef struct { logic [2:0] vec; logic sp; string tag; } exp_t;
    exp_t exp_q[$];

    always #2.5 clk = ~clk;

    pic_irq_capture dut_i (
        .clk_i(clk), .rst_ni(rst_ni), .req_i(req),
        .mode_we_i(mode_we), .mode_level_i(mode_level),
        .mask_we_i(mask_we), .mask_wdata_i(mask_wdata),
        .inta_i(inta), .eoi_i(eoi),
        .irr_o(irr), .isr_o(isr), .int_o(intr),
        .vec_valid_o(vec_valid), .vec_o(vec), .spurious_o(spurious)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic ack_first();
        inta = 1'b1; cyc(2); inta = 1'b0; cyc(2);
    endtask

    task automatic ack_second(input logic [2:0] v, input logic sp, input string tag);
        exp_t e;
        e.vec = v; e.sp = sp; e.tag = tag;
        exp_q.push_back(e);
        inta = 1'b1; cyc(2); inta = 1'b0; cyc(2);
    endtask

    task automatic ack(input logic [2:0] v, input logic sp, input string tag);
        ack_first();
        ack_second(v, sp, tag);
    endtask

    task automatic pulse_eoi();
        eoi = 1'b1; cyc(1); eoi = 1'b0; cyc(2);
    endtask

    task automatic set_mask(input logic [7:0] m);
        mask_wdata = m; mask_we = 1'b1; cyc(1); mask_we = 1'b0; cyc(1);
    endtask

    task automatic set_mode(input logic lvl);
        mode_level = lvl; mode_we = 1'b1; cyc(1); mode_we = 1'b0; cyc(1);
    endtask

    // monitor: compare each answer against the scoreboard queue
    always @(negedge clk) begin
        if (rst_ni && vec_valid) begin
            n_cmp++;
            if (exp_q.size() == 0) begin
                n_bad++;
                $display("FAIL R7: unexpected answer actual vec=%0d sp=%0b expected none", vec, spurious);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                if (vec !== e.vec || spurious !== e.sp) begin
                    n_bad++;
                    $display("FAIL %s: actual vec=%0d sp=%0b expected vec=%0d sp=%0b",
                             e.tag, vec, spurious, e.vec, e.sp);
                end
            end
        end
    end

    initial begin
        cyc(4);
        rst_ni = 1'b1;
        cyc(1);
        // R1 reset state
        chk("R1 irr", irr, 8'h00);
        chk("R1 isr", isr, 8'h00);
        chk("R1 int", intr, 1'b0);
        chk("R1 valid", vec_valid, 1'b0);
        req[3] = 1'b1; cyc(4);
        chk("R1 masked after reset irr", irr, 8'h08);
        chk("R1 masked after reset int", intr, 1'b0);
        // R11 mask write unmasks
        set_mask(8'h00);
        chk("R11 unmasked int", intr, 1'b1);
        // R7 grant
        ack(3'd3, 1'b0, "R7 grant 3");
        chk("R7 isr", isr, 8'h08);
        chk("R7 irr cleared", irr, 8'h00);
        chk("R5 blocked by service", intr, 1'b0);
        cyc(6);
        chk("R2 held high no re-arm", irr, 8'h00);
        pulse_eoi();
        chk("R10 eoi clears", isr, 8'h00);
        chk("R2 still idle after eoi", intr, 1'b0);
        req[3] = 1'b0; cyc(4);
        req[3] = 1'b1; cyc(4);
        chk("R2 new edge re-arms", irr, 8'h08);
        req[3] = 1'b0; cyc(4);
        chk("R4 fall clears edge", irr, 8'h00);
        // R6 priority and freeze
        req[5] = 1'b1; req[2] = 1'b1; cyc(4);
        ack(3'd2, 1'b0, "R6 lowest wins");
        chk("R6 isr", isr, 8'h04);
        pulse_eoi();
        req[2] = 1'b0; cyc(4);
        ack_first();
        req[1] = 1'b1; cyc(4);
        chk("R6 both pending", irr, 8'h22);
        ack_second(3'd5, 1'b0, "R6 frozen candidate");
        chk("R5 higher pri passes", intr, 1'b1);
        ack(3'd1, 1'b0, "R7 nested grant 1");
        chk("R10 two in service", isr, 8'h22);
        pulse_eoi();
        chk("R10 lowest cleared first", isr, 8'h20);
        pulse_eoi();
        chk("R10 second eoi", isr, 8'h00);
        req[1] = 1'b0; req[5] = 1'b0; cyc(4);
        // R8 drop between acknowledges
        req[4] = 1'b1; cyc(4);
        ack_first();
        req[4] = 1'b0; cyc(4);
        chk("R4 drop mid ack", irr, 8'h00);
        ack_second(3'd7, 1'b1, "R8 spurious");
        chk("R8 no isr", isr, 8'h00);
        // R9 drop before first acknowledge
        req[6] = 1'b1; cyc(4);
        chk("R9 pending", intr, 1'b1);
        req[6] = 1'b0; cyc(4);
        chk("R9 lost int", intr, 1'b0);
        ack(3'd7, 1'b1, "R9 nothing pending");
        // R3 level mode
        req[0] = 1'b1; cyc(4);
        set_mode(1'b1);
        ack(3'd0, 1'b0, "R3 level grant 0");
        chk("R3 level re-sets", irr, 8'h01);
        chk("R5 blocked by own service", intr, 1'b0);
        pulse_eoi();
        chk("R5 after eoi", intr, 1'b1);
        req[0] = 1'b0; cyc(4);
        chk("R4 fall clears level", irr, 8'h00);
        // R11 masked input not chosen
        set_mask(8'h02);
        req[1] = 1'b1; cyc(4);
        chk("R11 masked shows", irr, 8'h02);
        chk("R11 masked no int", intr, 1'b0);
        ack(3'd7, 1'b1, "R11 masked not chosen");
        chk("R11 no isr", isr, 8'h00);
        req[1] = 1'b0; cyc(4);
        n_cmp++;
        if (exp_q.size() != 0) begin
            n_bad++;
            $display("FAIL R7: answers missing actual %0d expected 0", exp_q.size());
        end
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule